// File: doc/BRIEF.md
# Memory-Area Chip-Select and Wait Controller

This block sits between a processor's internal bus and the external memory pins. It decodes a 32-bit physical address into one of three areas. For the two external areas it drives the chip-select, the read strobe (usable as an output enable) and per-byte write strobes for a static-memory-style access. The third area is routed to an internal peripheral select instead. A programmed wait count stretches each access. For the areas that allow it, an active-low external wait pin can hold the cycle open for as long as it stays low.

The requester raises `req_i` for at least one cycle with the address, size and direction valid, and lowers it no later than the cycle in which `ack_o` is high. The request is sampled only while the block is idle. The access ends with a one-cycle `ack_o`. Read data is captured into `rdata_o` at the clock edge that closes that cycle. Address bits 31..29 take no part in the decode, so every area is repeated every 0x2000_0000 bytes.

Top module: `memarea_ctrl`

## Requirements
- R1: The area is taken from address bits 28..26 alone: 000 selects area 0, 001 selects area 1 and 010 selects area 2. Bits 31..29 have no effect on which area is selected.
- R2: During an area-0 access `cs0_n_o` is low for every cycle of the access. At most one of {area-0 select, area-2 select, peripheral select} is active at any time.
- R3: An area-0 access keeps its strobes active for W+1 cycles, and `ack_o` is high in the last of them. W comes from the 3-bit `a0_wait_sel_i`: values 0..4 give W equal to the value, and 5, 6 and 7 give 6, 8 and 10.
- R4: An area-2 access drives `cs2_n_o` low for W+1 cycles, where W equals the 2-bit `a2_wait_sel_i` (0..3).
- R5: For area 0, and for area 2 while `a2_plain_mem_i` is 1, `wait_n_i` is checked in the last programmed cycle. While it is low the access, and all its strobes, stay active, and `ack_o` comes only in a cycle in which it is high.
- R6: For area 2 while `a2_plain_mem_i` is 0, `wait_n_i` has no effect on the length of the access.
- R7: An area-1 access raises `periph_sel_o` for exactly one cycle, ignores `wait_n_i` and the wait fields, and keeps `cs0_n_o`, `cs2_n_o`, `rd_n_o` and all of `we_n_o` high.
- R8: On writes to areas 0 and 2, `we_n_o[n]` is low only for the lanes covered by the access. Size 0 is a byte and covers lane n = addr[1:0]. Size 1 is a halfword and covers lanes 1..0 when addr[1] is 0, and lanes 3..2 when addr[1] is 1. Sizes 2 and 3 are a word and cover all four lanes. On these writes `rd_n_o` stays high. On reads `we_n_o` is all ones and `rd_n_o` is low.
- R9: An address whose bits 28..26 are 011 to 111 drives no select or strobe. It is answered one cycle after the request with `ack_o` and `err_o` both high, and it leaves `rdata_o` unchanged.
- R10: `ack_o` is a one-cycle pulse. On a successful read, `rdata_o` takes the value `ext_rdata_i` had in the ack cycle and holds it until the next successful read.
- R11: After reset all selects and strobes are inactive, and `ack_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| addr_i | input | 32 | Physical byte address |
| ack_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | With `ack_o`: address decoded to no area |
| rdata_o | output | 32 | Captured read data |
| a0_wait_sel_i | input | 3 | Area-0 wait code |
| a2_wait_sel_i | input | 2 | Area-2 wait count |
| a2_plain_mem_i | input | 1 | 1 = area 2 holds static memory, so `wait_n_i` is honoured |
| wait_n_i | input | 1 | Active-low external wait |
| ext_rdata_i | input | 32 | Data from the external bus |
| cs0_n_o | output | 1 | Area-0 chip-select, active low |
| cs2_n_o | output | 1 | Area-2 chip-select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| we_n_o | output | 4 | Per-lane write strobes, active low |
| periph_sel_o | output | 1 | Internal peripheral select for area 1 |

## Verification
A request is sampled at a rising edge, and the selects and strobes become visible in the cycle after that edge. That cycle is counted as cycle 1. With no external wait, `ack_o` appears in cycle W+1, where W is the decoded wait count. With an external wait held low through cycle H, `ack_o` appears in cycle max(W+1, H+1). An error reply is always in cycle 1. `rdata_o` changes at the edge that closes the ack cycle. Each scenario task therefore moves `wait_n_i` at the falling edge that opens the second half of a cycle, and samples every output 1 ns after that falling edge. It counts the cycles until the ack, and it checks `rdata_o` and the idle strobe state one cycle after the ack.

// File: rtl/memarea_pkg.sv
// Shared types for the memory-area controller.
// Assumes: at most four area codes (three areas plus "none").
package memarea_pkg;

    typedef enum logic [1:0] {
        AR_ZERO = 2'd0,
        AR_ONE  = 2'd1,
        AR_TWO  = 2'd2,
        AR_NONE = 2'd3
    } area_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD2 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FAIL = 2'd2
    } state_e;

endpackage

// File: rtl/memarea_decode.sv
// Address decode: picks the area from the area field and builds the byte-lane mask.
// Assumes: little-endian lane numbering, and naturally aligned accesses.
module memarea_decode
    import memarea_pkg::*;
#(
    parameter int AREA_W = 3,
    parameter int LANES  = 4,
    localparam int LSB_W = $clog2(LANES)
) (
    input  logic [AREA_W-1:0] area_field_i,
    input  logic [LSB_W-1:0]  low_addr_i,
    input  logic [1:0]        size_i,
    output area_e             area_o,
    output logic [LANES-1:0]  lane_mask_o
);

    // Area field to area code; every code above 2 is unmapped.
    always_comb begin
        case (area_field_i)
            AREA_W'(0): area_o = AR_ZERO;
            AREA_W'(1): area_o = AR_ONE;
            AREA_W'(2): area_o = AR_TWO;
            default:    area_o = AR_NONE;
        endcase
    end

    // One lane-enable term per byte lane.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        localparam logic [LSB_W-1:0] LN = LSB_W'(ln);
        always_comb begin
            case (size_e'(size_i))
                SZ_BYTE: lane_mask_o[ln] = (low_addr_i == LN);
                SZ_HALF: lane_mask_o[ln] = (low_addr_i[LSB_W-1:1] == LN[LSB_W-1:1]);
                default: lane_mask_o[ln] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/memarea_waitsel.sv
// Wait selection: turns the per-area wait fields into a cycle count.
// It also says whether the external wait pin applies to the area.
// Assumes: area 1 is an internal single-cycle target.
module memarea_waitsel
    import memarea_pkg::*;
#(
    parameter int A0_SEL_W = 3,
    parameter int A2_SEL_W = 2,
    parameter int CNT_W    = 4
) (
    input  area_e               area_i,
    input  logic [A0_SEL_W-1:0] a0_sel_i,
    input  logic [A2_SEL_W-1:0] a2_sel_i,
    input  logic                a2_plain_i,
    output logic [CNT_W-1:0]    waits_o,
    output logic                honour_o
);

    localparam logic [A0_SEL_W-1:0] LIN_MAX = A0_SEL_W'(4);

    logic [CNT_W-1:0] a0_waits;

    // Area-0 code: linear up to 4, then steps of two.
    always_comb begin
        if (a0_sel_i <= LIN_MAX)
            a0_waits = CNT_W'(a0_sel_i);
        else
            a0_waits = CNT_W'({a0_sel_i, 1'b0}) - CNT_W'(4);
    end

    // Per-area count and external-wait permission.
    always_comb begin
        case (area_i)
            AR_ZERO: begin waits_o = a0_waits;           honour_o = 1'b1;       end
            AR_TWO:  begin waits_o = CNT_W'(a2_sel_i);   honour_o = a2_plain_i; end
            default: begin waits_o = '0;                 honour_o = 1'b0;       end
        endcase
    end

endmodule

// File: rtl/memarea_ctrl.sv
// Top level: the access sequencer and the pin drivers for areas 0 to 2.
// Assumes: req_i is sampled only while idle, and the requester drops it by the ack cycle.
module memarea_ctrl
    import memarea_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int AREA_LSB = 26,
    parameter int AREA_W   = 3,
    parameter int A0_SEL_W = 3,
    parameter int A2_SEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic                we_i,
    input  logic [1:0]          size_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic                ack_o,
    output logic                err_o,
    output logic [DATA_W-1:0]   rdata_o,
    input  logic [A0_SEL_W-1:0] a0_wait_sel_i,
    input  logic [A2_SEL_W-1:0] a2_wait_sel_i,
    input  logic                a2_plain_mem_i,
    input  logic                wait_n_i,
    input  logic [DATA_W-1:0]   ext_rdata_i,
    output logic                cs0_n_o,
    output logic                cs2_n_o,
    output logic                rd_n_o,
    output logic [DATA_W/8-1:0] we_n_o,
    output logic                periph_sel_o
);

    localparam int LANES  = DATA_W / 8;
    localparam int LSB_W  = $clog2(LANES);
    localparam int A0_MAX = 2 * ((1 << A0_SEL_W) - 1) - 4;
    localparam int CNT_W  = $clog2(A0_MAX + 1);

    area_e            dec_area;
    logic [LANES-1:0] dec_mask;
    logic [CNT_W-1:0] dec_waits;
    logic             dec_honour;

    state_e           st_q;
    area_e            area_q;
    logic             we_q;
    logic [LANES-1:0] mask_q;
    logic [CNT_W-1:0] cnt_q;
    logic             honour_q;
    logic [DATA_W-1:0] rdata_q;

    logic busy, ext_busy, last_cyc;
    logic unused_addr;

    assign unused_addr = ^{addr_i[ADDR_W-1:AREA_LSB+AREA_W], addr_i[AREA_LSB-1:LSB_W]};

    memarea_decode #(.AREA_W(AREA_W), .LANES(LANES)) u_decode (
        .area_field_i (addr_i[AREA_LSB +: AREA_W]),
        .low_addr_i   (addr_i[LSB_W-1:0]),
        .size_i       (size_i),
        .area_o       (dec_area),
        .lane_mask_o  (dec_mask)
    );

    memarea_waitsel #(.A0_SEL_W(A0_SEL_W), .A2_SEL_W(A2_SEL_W), .CNT_W(CNT_W)) u_waitsel (
        .area_i     (dec_area),
        .a0_sel_i   (a0_wait_sel_i),
        .a2_sel_i   (a2_wait_sel_i),
        .a2_plain_i (a2_plain_mem_i),
        .waits_o    (dec_waits),
        .honour_o   (dec_honour)
    );

    // Access status derived from the state register.
    assign busy     = (st_q == ST_RUN);
    assign ext_busy = busy && (area_q != AR_ONE);
    assign last_cyc = busy && (cnt_q == '0) && !(honour_q && !wait_n_i);

    // Sequencer: accept in idle, count down the waits, finish on the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            area_q   <= AR_NONE;
            we_q     <= 1'b0;
            mask_q   <= '0;
            cnt_q    <= '0;
            honour_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (req_i) begin
                    st_q     <= (dec_area == AR_NONE) ? ST_FAIL : ST_RUN;
                    area_q   <= dec_area;
                    we_q     <= we_i;
                    mask_q   <= dec_mask;
                    cnt_q    <= dec_waits;
                    honour_q <= dec_honour;
                end
                ST_RUN: begin
                    if (last_cyc)
                        st_q <= ST_IDLE;
                    else if (cnt_q != '0)
                        cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Read data capture at the close of a successful read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (last_cyc && !we_q)
            rdata_q <= ext_rdata_i;
    end

    // Pin drivers; area 1 reaches only the internal select.
    assign cs0_n_o      = !(busy && area_q == AR_ZERO);
    assign cs2_n_o      = !(busy && area_q == AR_TWO);
    assign periph_sel_o = busy && (area_q == AR_ONE);
    assign rd_n_o       = !(ext_busy && !we_q);
    assign we_n_o       = (ext_busy && we_q) ? ~mask_q : '1;
    assign ack_o        = last_cyc || (st_q == ST_FAIL);
    assign err_o        = (st_q == ST_FAIL);
    assign rdata_o      = rdata_q;

    // R2
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!cs0_n_o, !cs2_n_o, periph_sel_o}));
    // R7
    periph_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periph_sel_o |-> (cs0_n_o && cs2_n_o && rd_n_o && (&we_n_o)));
    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (ack_o && cs0_n_o && cs2_n_o && rd_n_o && (&we_n_o) && !periph_sel_o));
    // R9
    err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> $stable(rdata_o));
    // R5
    cs0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs0_n_o && !ack_o) |=> !cs0_n_o);
    // R5
    a0_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs0_n_o && !wait_n_i) |-> !ack_o);
    // R8
    rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !(&we_n_o)));

endmodule

// File: tb/memarea_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module memarea_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, we_i = 1'b0;
    logic [1:0]  size_i = 2'd2;
    logic [31:0] addr_i = '0;
    logic        ack_o, err_o;
    logic [31:0] rdata_o;
    logic [2:0]  a0_wait_sel_i = '0;
    logic [1:0]  a2_wait_sel_i = '0;
    logic        a2_plain_mem_i = 1'b1;
    logic        wait_n_i = 1'b1;
    logic [31:0] ext_rdata_i = '0;
    logic        cs0_n_o, cs2_n_o, rd_n_o, periph_sel_o;
    logic [3:0]  we_n_o;

    int n_run = 0, n_fail = 0;
    logic [31:0] last_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memarea_ctrl u_memarea_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .size_i(size_i),
        .addr_i(addr_i), .ack_o(ack_o), .err_o(err_o), .rdata_o(rdata_o),
        .a0_wait_sel_i(a0_wait_sel_i), .a2_wait_sel_i(a2_wait_sel_i),
        .a2_plain_mem_i(a2_plain_mem_i), .wait_n_i(wait_n_i), .ext_rdata_i(ext_rdata_i),
        .cs0_n_o(cs0_n_o), .cs2_n_o(cs2_n_o), .rd_n_o(rd_n_o), .we_n_o(we_n_o),
        .periph_sel_o(periph_sel_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One access. kind: 0/1/2 = area, 3 = unmapped. wait_n_i is low through cycle 'hold'.
    task automatic access(input logic [31:0] addr, input logic [1:0] sz, input bit wr,
                          input int hold, input int exp_cyc, input int kind,
                          input logic [3:0] exp_wen, input string req);
        int cyc = 0;
        bit got = 0, bad = 0, err_seen = 0;
        logic [7:0] pins, want;
        @(negedge clk);
        addr_i = addr; size_i = sz; we_i = wr; req_i = 1'b1;
        ext_rdata_i = addr ^ 32'h5A3C_96E1;
        while (!got && cyc < 64) begin
            @(negedge clk);
            req_i = 1'b0;
            cyc++;
            wait_n_i = (cyc > hold);
            #1;
            pins = {cs0_n_o, cs2_n_o, periph_sel_o, rd_n_o, we_n_o};
            want = {kind != 0, kind != 2, kind == 1,
                    !((kind == 0 || kind == 2) && !wr),
                    ((kind == 0 || kind == 2) && wr) ? exp_wen : 4'hF};
            if (pins != want) bad = 1;
            if (ack_o) begin got = 1; err_seen = err_o; end
        end
        wait_n_i = 1'b1;
        check(!bad, {req, " strobes"}, 32'(pins), 32'(want));
        check(cyc == exp_cyc, {req, " cycles"}, cyc, exp_cyc);
        check(err_seen == (kind == 3), {req, " err"}, err_seen, kind == 3);
        @(negedge clk); #1;
        check({ack_o, cs0_n_o, cs2_n_o, periph_sel_o, rd_n_o, we_n_o} == 9'b0_1101_1111,
              "R10 pulse/idle", {ack_o, cs0_n_o, cs2_n_o, periph_sel_o, rd_n_o, we_n_o}, 9'h0DF);
        if (!wr && kind != 3) last_rd = addr ^ 32'h5A3C_96E1;
        check(rdata_o == last_rd, {req, " rdata"}, rdata_o, last_rd);
    endtask

    task automatic t_reset();
        // R11
        check({ack_o, err_o, cs0_n_o, cs2_n_o, periph_sel_o, rd_n_o, we_n_o} == 10'b00_1101_1111,
              "R11 reset", {ack_o, err_o, cs0_n_o, cs2_n_o, periph_sel_o, rd_n_o, we_n_o}, 10'h0DF);
    endtask

    task automatic t_area0_waits();
        a0_wait_sel_i = 3'd0; access(32'h0000_0100, 2'd2, 0, 0, 1, 0, 4'hF, "R2 R3 a0 w0");
        a0_wait_sel_i = 3'd3; access(32'h0000_0104, 2'd2, 0, 0, 4, 0, 4'hF, "R3 a0 code3");
        a0_wait_sel_i = 3'd5; access(32'h0000_0108, 2'd2, 0, 0, 7, 0, 4'hF, "R3 a0 code5");
        a0_wait_sel_i = 3'd7; access(32'h0000_010C, 2'd2, 0, 0, 11, 0, 4'hF, "R3 a0 code7");
    endtask

    task automatic t_shadow();
        a0_wait_sel_i = 3'd0; a2_wait_sel_i = 2'd0;
        access(32'hE000_0010, 2'd2, 0, 0, 1, 0, 4'hF, "R1 shadow a0");
        access(32'hA800_0020, 2'd2, 0, 0, 1, 2, 4'hF, "R1 shadow a2");
        access(32'h6400_0030, 2'd2, 0, 0, 1, 1, 4'hF, "R1 shadow a1");
    endtask

    task automatic t_area2_waits();
        a2_wait_sel_i = 2'd3; access(32'h0800_0040, 2'd2, 0, 0, 4, 2, 4'hF, "R4 a2 w3");
        a2_wait_sel_i = 2'd1; access(32'h0800_0044, 2'd2, 0, 0, 2, 2, 4'hF, "R4 a2 w1");
    endtask

    task automatic t_ext_wait();
        a0_wait_sel_i = 3'd2; access(32'h0000_0200, 2'd2, 0, 6, 7, 0, 4'hF, "R5 a0 held");
        a2_plain_mem_i = 1'b1; a2_wait_sel_i = 2'd1;
        access(32'h0800_0200, 2'd2, 0, 4, 5, 2, 4'hF, "R5 a2 plain held");
        a2_plain_mem_i = 1'b0;
        access(32'h0800_0204, 2'd2, 0, 4, 2, 2, 4'hF, "R6 a2 not plain");
        a2_plain_mem_i = 1'b1;
    endtask

    task automatic t_area1();
        a0_wait_sel_i = 3'd7; a2_wait_sel_i = 2'd3;
        access(32'h0400_0010, 2'd2, 0, 3, 1, 1, 4'hF, "R7 a1 read");
        access(32'h0400_0014, 2'd2, 1, 0, 1, 1, 4'hF, "R7 a1 write");
    endtask

    task automatic t_lanes();
        a0_wait_sel_i = 3'd0; a2_wait_sel_i = 2'd0;
        access(32'h0000_0302, 2'd0, 1, 0, 1, 0, 4'b1011, "R8 byte lane2");
        access(32'h0000_0301, 2'd0, 1, 0, 1, 0, 4'b1101, "R8 byte lane1");
        access(32'h0800_0302, 2'd1, 1, 0, 1, 2, 4'b0011, "R8 half upper");
        access(32'h0800_0300, 2'd1, 1, 0, 1, 2, 4'b1100, "R8 half lower");
        access(32'h0000_0300, 2'd2, 1, 0, 1, 0, 4'b0000, "R8 word");
    endtask

    task automatic t_unmapped();
        access(32'h0C00_0000, 2'd2, 0, 0, 1, 3, 4'hF, "R9 code3");
        access(32'h1C00_0040, 2'd2, 1, 0, 1, 3, 4'hF, "R9 code7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        t_area0_waits();
        t_shadow();
        t_area2_waits();
        t_ext_wait();
        t_area1();
        t_lanes();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule